// File: doc/BRIEF.md
# Video RAM Block-Copy DMA

This block copies data from anywhere in the 16-bit system address space into the video RAM window (0x8000 to 0x9FFF). It moves the data in 16-byte units. Software programs a source address, a destination address and a length/mode byte through a small byte-wide register port. Writing the length/mode byte starts the copy.

There are two kinds of copy:

- **Immediate copy.** The whole block moves at once. The CPU is stalled for the full duration.
- **Paced copy.** The block is armed, and each rising edge of the horizontal-blank input moves exactly one 16-byte unit.

The block drives a byte-wide master bus. Each byte takes one read cycle followed by one write cycle. When a transfer ends, the block stores the advanced addresses back into its address registers. It also reports progress through the length/mode byte.

Address forcing:

- The low four bits of both addresses are always cleared.
- The destination is always placed inside the video RAM window.
- A source that lies inside the video RAM window is refused.

Top module: `vram_dma`

## Requirements
- R1: After reset the four address registers (selectors 0 to 3: source high, source low, destination high, destination low) read 0x00. The length/mode register (selector 4) reads 0xFF. `busy_o`, `stall_o`, `mem_rd_o` and `mem_wr_o` are low.
- R2: The effective source is {src_hi,src_lo} with bits 3:0 cleared. Byte i of a transfer is read from the effective source plus i. The value read is written unchanged to the destination.
- R3: The effective destination is 0x8000 | ({dst_hi,dst_lo} & 0x1FF0). Every write lands in 0x8000–0x9FFF. The destination advances within the low 13 bits, so it wraps from 0x9FFF to 0x8000.
- R4: Writing the length/mode register with bit 7 clear starts an immediate copy of (bits 6:0 + 1) × 16 bytes. Each byte takes a read cycle and then a write cycle. `busy_o` and `stall_o` go high the cycle after the register write and stay high for exactly 2 × bytes cycles.
- R5: A start whose effective source lies in 0x8000–0x9FFF is ignored. No bus cycle occurs, and the length/mode register keeps its previous value.
- R6: When a transfer or a unit ends, the address registers hold the final source (effective source + bytes) and the final destination (wrapped as in R3).
- R7: At the end of an immediate copy, the length/mode register reads the written value with bit 7 set.
- R8: Writing the length/mode register with bit 7 set arms paced mode and starts no copy. While armed, the register reads bits 6:0 of the written value with bit 7 clear.
- R9: In paced mode, each rising edge of `hblank_i` on an idle block starts one 16-byte unit. The unit begins at the current address registers, and the length/mode register decrements by one when the unit ends.
- R10: Paced mode ends when the length/mode register decrements to 0xFF. Later `hblank_i` edges move nothing.
- R11: `hblank_i` is edge-sensitive. Holding it high, or raising it while a unit is in progress, moves no extra unit.
- R12: Writing the length/mode register with bit 7 clear while paced mode is armed cancels the mode. A unit in progress finishes and decrements the register, and then bit 7 is set. If no unit is in progress, bit 7 is set at once. No later edge moves data.
- R13: Register writes while `busy_o` is high are ignored, except for the cancel in R12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register selector: 0 src hi, 1 src lo, 2 dst hi, 3 dst lo, 4 length/mode |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register (0xFF for unused selectors) |
| hblank_i | input | 1 | Horizontal-blank indication; its rising edge paces paced mode |
| mem_addr_o | output | 16 | Master bus address |
| mem_rd_o | output | 1 | Master read strobe; read data is taken in the same cycle |
| mem_rdata_i | input | 8 | Master read data |
| mem_wr_o | output | 1 | Master write strobe |
| mem_wdata_o | output | 8 | Master write data |
| busy_o | output | 1 | High while a copy or a unit is in progress |
| stall_o | output | 1 | CPU hold request, high for the whole duration of a copy or unit |

## Verification
The bench sweeps the low nibbles of both addresses and several lengths. It checks every written byte against an address-derived data pattern, so a design that failed to mask an address, skipped a byte or shifted the stream by one would miscompare. The bench also puts the destination at the top of the window, where a design without the 13-bit wrap would write outside video RAM. In paced mode it checks:

- A held and a repeated `hblank_i`, where a level-sensitive design would move extra units.
- The count running down to 0xFF, where an off-by-one design would stop a unit early or run one unit too many.
- A cancel both during a unit and while idle.
- Refused sources and ignored writes during a busy copy, where a careless design would start a copy or corrupt the write-back.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned WIN_W   = 13;
  localparam logic [ADDR_W-WIN_W-1:0] WIN_TAG = 3'b100;

  localparam logic [2:0] SEL_SRC_HI = 3'd0;
  localparam logic [2:0] SEL_SRC_LO = 3'd1;
  localparam logic [2:0] SEL_DST_HI = 3'd2;
  localparam logic [2:0] SEL_DST_LO = 3'd3;
  localparam logic [2:0] SEL_CTL    = 3'd4;

  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_RD   = 2'd1,
    MV_WR   = 2'd2
  } mv_state_e;
endpackage

// File: rtl/vdma_mover.sv
module vdma_mover
  import vdma_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              busy_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] src_nxt_o,
  output logic [ADDR_W-1:0] dst_nxt_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o
);
  mv_state_e         state_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  rem_q;
  logic [7:0]        data_q;

  assign src_nxt_o   = src_q + ADDR_W'(1);
  // destination stays inside the window
  assign dst_nxt_o   = {dst_q[ADDR_W-1:WIN_W], dst_q[WIN_W-1:0] + WIN_W'(1)};
  assign busy_o      = (state_q != MV_IDLE);
  assign mem_rd_o    = (state_q == MV_RD);
  assign mem_wr_o    = (state_q == MV_WR);
  assign mem_addr_o  = mem_wr_o ? dst_q : src_q;
  assign mem_wdata_o = data_q;
  assign last_o      = mem_wr_o && (rem_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MV_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        MV_IDLE: if (start_i) begin
          src_q   <= src_i;
          dst_q   <= dst_i;
          rem_q   <= len_i;
          state_q <= MV_RD;
        end
        MV_RD: begin
          data_q  <= mem_rdata_i;
          state_q <= MV_WR;
        end
        MV_WR: begin
          src_q   <= src_nxt_o;
          dst_q   <= dst_nxt_o;
          rem_q   <= rem_q - CNT_W'(1);
          state_q <= last_o ? MV_IDLE : MV_RD;
        end
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  assert_rd_then_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> mem_wr_o);
  assert_rd_wr_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  assert_wr_in_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_addr_o[ADDR_W-1:WIN_W] == WIN_TAG));
  assert_start_src_ok_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (src_i[ADDR_W-1:WIN_W] != WIN_TAG));
endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
  import vdma_pkg::*;
#(
  parameter int unsigned LEN_W    = 7,
  parameter int unsigned CHUNK_LG = 4,
  parameter int unsigned CNT_W    = LEN_W + CHUNK_LG + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              hblank_i,
  input  logic              eng_busy_i,
  input  logic              eng_last_i,
  input  logic [ADDR_W-1:0] src_nxt_i,
  input  logic [ADDR_W-1:0] dst_nxt_i,
  output logic              start_o,
  output logic [CNT_W-1:0]  len_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o
);
  localparam int unsigned HI_KEEP = WIN_W - REG_W;

  logic [REG_W-1:0] src_hi_q, src_lo_q, dst_hi_q, dst_lo_q, ctl_q;
  logic hb_arm_q, hb_chunk_q, cancel_q, hb_prev_q;

  logic src_bad, ctl_wr, gen_go, arm_go, cancel_req, hb_rise, chunk_go;
  logic [REG_W-1:0] ctl_dec;

  assign src_o = {src_hi_q, src_lo_q[REG_W-1:CHUNK_LG], CHUNK_LG'(0)};
  assign dst_o = {WIN_TAG, dst_hi_q[HI_KEEP-1:0], dst_lo_q[REG_W-1:CHUNK_LG], CHUNK_LG'(0)};
  assign src_bad = (src_o[ADDR_W-1:WIN_W] == WIN_TAG);

  assign ctl_wr     = we_i && (sel_i == SEL_CTL) && !eng_busy_i;
  assign gen_go     = ctl_wr && !src_bad && !hb_arm_q && !wdata_i[LEN_W];
  assign arm_go     = ctl_wr && !src_bad && !hb_arm_q &&  wdata_i[LEN_W];
  assign cancel_req = we_i && (sel_i == SEL_CTL) && hb_arm_q && !wdata_i[LEN_W];
  assign hb_rise    = hblank_i && !hb_prev_q;
  assign chunk_go   = hb_rise && hb_arm_q && !cancel_q && !cancel_req && !eng_busy_i && !src_bad;
  assign start_o    = gen_go || chunk_go;
  assign len_o      = gen_go
                    ? CNT_W'((CNT_W'(wdata_i[LEN_W-1:0]) + CNT_W'(1)) << CHUNK_LG)
                    : CNT_W'(CNT_W'(1) << CHUNK_LG);
  assign ctl_dec    = ctl_q - REG_W'(1);

  always_comb begin
    unique case (sel_i)
      SEL_SRC_HI: rdata_o = src_hi_q;
      SEL_SRC_LO: rdata_o = src_lo_q;
      SEL_DST_HI: rdata_o = dst_hi_q;
      SEL_DST_LO: rdata_o = dst_lo_q;
      SEL_CTL:    rdata_o = ctl_q;
      default:    rdata_o = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_hi_q   <= '0;
      src_lo_q   <= '0;
      dst_hi_q   <= '0;
      dst_lo_q   <= '0;
      ctl_q      <= '1;
      hb_arm_q   <= 1'b0;
      hb_chunk_q <= 1'b0;
      cancel_q   <= 1'b0;
      hb_prev_q  <= 1'b0;
    end else begin
      hb_prev_q <= hblank_i;
      if (we_i && !eng_busy_i) begin
        unique case (sel_i)
          SEL_SRC_HI: src_hi_q <= wdata_i;
          SEL_SRC_LO: src_lo_q <= wdata_i;
          SEL_DST_HI: dst_hi_q <= wdata_i;
          SEL_DST_LO: dst_lo_q <= wdata_i;
          default: ;
        endcase
      end
      if (gen_go) begin
        ctl_q      <= wdata_i;
        hb_chunk_q <= 1'b0;
      end
      if (arm_go) begin
        ctl_q    <= {1'b0, wdata_i[LEN_W-1:0]};
        hb_arm_q <= 1'b1;
      end
      if (chunk_go) hb_chunk_q <= 1'b1;
      if (cancel_req) begin
        if (eng_busy_i) cancel_q <= 1'b1;
        else begin
          hb_arm_q     <= 1'b0;
          ctl_q[LEN_W] <= 1'b1;
        end
      end
      if (eng_last_i) begin
        {src_hi_q, src_lo_q} <= src_nxt_i;
        {dst_hi_q, dst_lo_q} <= dst_nxt_i;
        if (hb_chunk_q) begin
          if (cancel_q || cancel_req) begin
            ctl_q    <= ctl_dec | (REG_W'(1) << LEN_W);
            hb_arm_q <= 1'b0;
            cancel_q <= 1'b0;
          end else begin
            ctl_q <= ctl_dec;
            if (ctl_dec == '1) hb_arm_q <= 1'b0;
          end
        end else begin
          ctl_q[LEN_W] <= 1'b1;
        end
      end
    end
  end

  assert_mode_end_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hb_arm_q) |-> ctl_q[LEN_W]);
  assert_regs_frozen_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_busy_i && !eng_last_i) |=> $stable({src_hi_q, src_lo_q, dst_hi_q, dst_lo_q}));
  assert_start_when_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !eng_busy_i);
endmodule

// File: rtl/vram_dma.sv
module vram_dma
  import vdma_pkg::*;
#(
  parameter int unsigned LEN_W    = 7,
  parameter int unsigned CHUNK_LG = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_sel_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  input  logic        hblank_i,
  output logic [15:0] mem_addr_o,
  output logic        mem_rd_o,
  input  logic [7:0]  mem_rdata_i,
  output logic        mem_wr_o,
  output logic [7:0]  mem_wdata_o,
  output logic        busy_o,
  output logic        stall_o
);
  localparam int unsigned CNT_W = LEN_W + CHUNK_LG + 1;

  logic              start, last;
  logic [CNT_W-1:0]  len;
  logic [ADDR_W-1:0] src, dst, src_nxt, dst_nxt;

  vdma_ctrl #(.LEN_W(LEN_W), .CHUNK_LG(CHUNK_LG), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .hblank_i,
    .eng_busy_i(busy_o), .eng_last_i(last),
    .src_nxt_i(src_nxt), .dst_nxt_i(dst_nxt),
    .start_o(start), .len_o(len), .src_o(src), .dst_o(dst)
  );

  vdma_mover #(.CNT_W(CNT_W)) u_mover (
    .clk_i, .rst_ni,
    .start_i(start), .len_i(len), .src_i(src), .dst_i(dst),
    .mem_rdata_i,
    .busy_o, .last_o(last), .src_nxt_o(src_nxt), .dst_nxt_o(dst_nxt),
    .mem_addr_o, .mem_rd_o, .mem_wr_o, .mem_wdata_o
  );

  assign stall_o = busy_o;
endmodule

// File: tb/vram_dma_bench.sv
module vram_dma_bench;
  logic clk = 0, rst_n = 0;
  logic we = 0, hblank = 0;
  logic [2:0] sel = 3'd4;
  logic [7:0] wdata = 0, rdata, rdat_mem, wdat;
  logic [15:0] addr;
  logic rd, wr, busy, stall;

  int checks = 0, fails = 0;
  int busy_cnt = 0, wr_cnt = 0, bad_bytes = 0;
  logic [15:0] exp_src = 0, exp_dst = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign rdat_mem = pat(addr);

  vram_dma u_vram_dma (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .hblank_i(hblank), .mem_addr_o(addr), .mem_rd_o(rd),
    .mem_rdata_i(rdat_mem), .mem_wr_o(wr), .mem_wdata_o(wdat), .busy_o(busy), .stall_o(stall)
  );

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (wr) begin
      wr_cnt++;
      if (addr !== exp_dst || wdat !== pat(exp_src)) bad_bytes++;
      exp_dst = {3'b100, exp_dst[12:0] + 13'd1};
      exp_src = exp_src + 16'd1;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk); we = 1; sel = s; wdata = v;
    @(negedge clk); we = 0; sel = 3'd4;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [7:0] v);
    sel = s; #1; v = rdata; sel = 3'd4;
  endtask

  task automatic clr;
    busy_cnt = 0; wr_cnt = 0; bad_bytes = 0;
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
  endtask

  task automatic chk_regs(input string tag, input logic [15:0] s, input logic [15:0] d,
                          input logic [7:0] c);
    logic [7:0] a, b;
    rd_reg(3'd0, a); rd_reg(3'd1, b); chk({tag, " src"}, {a, b}, s);
    rd_reg(3'd2, a); rd_reg(3'd3, b); chk({tag, " dst"}, {a, b}, d);
    rd_reg(3'd4, a); chk({tag, " ctl"}, {8'h00, a}, {8'h00, c});
  endtask

  task automatic quiet(input string tag, input int n);
    clr; repeat (n) @(negedge clk);
    chk({tag, " no transfer"}, 16'(busy_cnt + wr_cnt), 16'd0);
  endtask

  task automatic pulse(input int hold);
    @(negedge clk); hblank = 1;
    repeat (hold) @(negedge clk);
    hblank = 0;
  endtask

  task automatic run_general(input logic [7:0] sh, sl, dh, dl, input logic [6:0] l);
    logic [15:0] s, d, n;
    s = {sh, sl} & 16'hFFF0;
    d = 16'h8000 | ({dh, dl} & 16'h1FF0);
    n = (16'(l) + 16'd1) * 16'd16;
    wr_reg(3'd0, sh); wr_reg(3'd1, sl); wr_reg(3'd2, dh); wr_reg(3'd3, dl);
    exp_src = s; exp_dst = d; clr;
    wr_reg(3'd4, {1'b0, l});
    chk("R4 busy after start", {15'd0, busy & stall}, 16'd1);
    wait_idle;
    chk("R4 busy cycles", 16'(busy_cnt), 16'(2 * n));
    chk("R2 byte count", 16'(wr_cnt), n);
    chk("R2 R3 byte stream", 16'(bad_bytes), 16'd0);
    chk_regs("R6 R7 writeback", s + n, {3'b100, d[12:0] + n[12:0]}, {1'b1, l});
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_regs("R1 reset", 16'h0000, 16'h0000, 8'hFF);
    chk("R1 idle outputs", {12'd0, busy, stall, rd, wr}, 16'd0);

    // R2 R3 R4 sweep over nibbles and lengths
    for (int l = 0; l < 3; l++)
      for (int nb = 0; nb < 16; nb++) begin
        logic [3:0] x;
        x = 4'(nb);
        run_general(x[3] ? (8'hC0 | {4'h0, x}) : {2'b00, x, 2'b01}, {x, ~x},
                    {~x, x}, {x, x}, 7'(l));
      end
    // R3 wrap at top of window
    run_general(8'h20, 8'h00, 8'h1F, 8'hF0, 7'd1);
    // R4 maximum length
    run_general(8'h00, 8'h00, 8'h00, 8'h00, 7'd127);

    // R5 source inside video RAM is refused
    wr_reg(3'd0, 8'h85); wr_reg(3'd1, 8'h00);
    wr_reg(3'd4, 8'h03);
    quiet("R5 refused start", 8);
    rd_reg(3'd4, v); chk("R5 ctl unchanged", {8'h0, v}, 16'h00FF);
    rd_reg(3'd0, v); chk("R5 src kept", {8'h0, v}, 16'h0085);

    // R8 arm paced mode
    wr_reg(3'd0, 8'h40); wr_reg(3'd1, 8'h07); wr_reg(3'd2, 8'h00); wr_reg(3'd3, 8'h40);
    exp_src = 16'h4000; exp_dst = 16'h8040;
    wr_reg(3'd4, 8'h82);
    quiet("R8 armed idle", 10);
    rd_reg(3'd4, v); chk("R8 armed ctl", {8'h0, v}, 16'h0002);

    // R9 R11 first unit with hblank held high long
    clr;
    @(negedge clk); hblank = 1;
    @(negedge clk);
    chk("R9 unit starts", {15'd0, busy}, 16'd1);
    repeat (50) @(negedge clk);
    hblank = 0;
    wait_idle;
    chk("R11 held level one unit", 16'(wr_cnt), 16'd16);
    chk("R9 unit busy cycles", 16'(busy_cnt), 16'd32);
    chk("R9 unit bytes", 16'(bad_bytes), 16'd0);
    chk_regs("R9 after unit 1", 16'h4010, 16'h8050, 8'h01);

    // R11 retrigger while busy ignored
    clr;
    pulse(2);
    repeat (6) @(negedge clk);
    pulse(2);
    wait_idle;
    chk("R11 retrigger ignored", 16'(wr_cnt), 16'd16);
    chk_regs("R9 after unit 2", 16'h4020, 16'h8060, 8'h00);

    // R10 last unit then mode ends
    clr;
    pulse(1); @(negedge clk); wait_idle;
    chk("R10 last unit bytes", 16'(wr_cnt), 16'd16);
    chk_regs("R10 end", 16'h4030, 16'h8070, 8'hFF);
    pulse(1);
    quiet("R10 no unit after end", 40);

    // R12 cancel during a unit
    wr_reg(3'd4, 8'h85);
    clr;
    pulse(1);
    repeat (5) @(negedge clk);
    wr_reg(3'd4, 8'h00);
    wait_idle;
    chk("R12 unit completes", 16'(wr_cnt), 16'd16);
    chk_regs("R12 cancel busy", 16'h4040, 16'h8080, 8'h84);
    pulse(1);
    quiet("R12 no unit after cancel", 40);

    // R12 cancel while idle
    wr_reg(3'd4, 8'h83);
    wr_reg(3'd4, 8'h00);
    rd_reg(3'd4, v); chk("R12 cancel idle ctl", {8'h0, v}, 16'h0083);
    pulse(1);
    quiet("R12 no unit idle cancel", 40);

    // R13 writes during an immediate copy are ignored
    wr_reg(3'd0, 8'h30); wr_reg(3'd1, 8'h00); wr_reg(3'd2, 8'h05); wr_reg(3'd3, 8'h00);
    exp_src = 16'h3000; exp_dst = 16'h8500; clr;
    wr_reg(3'd4, 8'h03);
    wr_reg(3'd4, 8'h85);
    wr_reg(3'd0, 8'h11);
    wr_reg(3'd3, 8'h77);
    wait_idle;
    chk("R13 bytes", 16'(wr_cnt), 16'd64);
    chk("R13 stream", 16'(bad_bytes), 16'd0);
    chk_regs("R13 writeback", 16'h3040, 16'h8540, 8'h83);
    pulse(1);
    quiet("R13 not armed", 40);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule